// File: doc/BRIEF.md
# CAN Message FIFO Mailbox Window

This block sits between a CPU register bus and a CAN protocol engine. It holds one four-entry transmit queue and one four-entry receive queue, each holding whole messages (identifier word, length code, eight data bytes). The CPU does not push or pop the queues through a port. It reaches them through two fixed mailbox windows in the register space. Outgoing messages are assembled in a staging window. Each one is then committed by writing the key value 0xFF to a transmit pointer register. An incoming message is read at the receive window and dropped with the same key written to a receive pointer register.

On the engine side, the transmit queue is offered with a valid/ready handshake. The engine signals with a one-cycle pulse when each popped message has actually been sent. The transmit control register reports how many committed messages are still waiting for that confirmation. Received frames arrive on a valid/ready interface. A frame that finds the receive queue full is not stored. It is counted in a saturating overrun counter. Two interrupt flags, one for each queue, are gated by enables and combined into a single interrupt line.

Top module: `can_fifo_window`

## Requirements
- R1: After reset, every register reads zero except the receive control register, which reads 0x80 (empty). `irq`, `eng_tx_valid` and `eng_rx_ready` are low.
- R2: Words 224..227 (mailbox 56) form the transmit staging window: identifier word, length code in bits 3:0, data bytes 0..3 (byte 0 in bits 7:0) and data bytes 4..7. The window reads back its contents. A committed message reaches the engine bit for bit, with the extended flag in bit 31, the remote flag in bit 30, a standard identifier in bits 28:18 and an extended identifier in bits 28:0.
- R3: A write to the transmit pointer register (0x101) commits the staging window only when the low byte is 0xFF and the transmit enable (bit 0 of 0x100) is set. Any other write to it has no effect.
- R4: Bits 3:1 of 0x100 give the unsent count: messages committed minus send confirmations. A commit while four are unsent is ignored. A confirmation while no popped message is awaiting one is ignored.
- R5: `eng_tx_valid` is high exactly when transmit is enabled and a committed message is stored. Messages are presented in commit order, and each is removed on valid and ready.
- R6: `eng_rx_ready` equals the receive enable (bit 0 of 0x102). Accepted frames are queued in arrival order. Words 240..243 (mailbox 60) show the oldest one, in the same layout as R2, and read zero when the queue is empty. Bit 7 of 0x102 reads 1 while the queue is empty.
- R7: Writing a low byte of 0xFF to the receive pointer register (0x103) removes the oldest received message. Other values, and a release while the queue is empty, change nothing.
- R8: A frame that arrives while the receive queue is full is dropped. It increments the overrun count at 0x106, which saturates at 255.
- R9: Status bit 4 of 0x105 sets when a received frame is stored. Status bit 3 sets on an accepted send confirmation. A write to 0x105 clears each of those bits that is written 0. A set in the same cycle wins over the clear. `irq` is high when a status bit and the same bit of the enable register 0x104 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 9 | Word address |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for `cpu_addr` (combinational) |
| irq | output | 1 | Combined queue interrupt |
| eng_tx_valid | output | 1 | Transmit message available |
| eng_tx_ready | input | 1 | Engine takes the offered message |
| eng_tx_id | output | 32 | Offered identifier word |
| eng_tx_dlc | output | 4 | Offered length code |
| eng_tx_data | output | 64 | Offered data, byte 0 in bits 7:0 |
| eng_tx_done | input | 1 | One message has been sent |
| eng_rx_valid | input | 1 | Received frame present |
| eng_rx_ready | output | 1 | Receive side enabled |
| eng_rx_id | input | 32 | Received identifier word |
| eng_rx_dlc | input | 4 | Received length code |
| eng_rx_data | input | 64 | Received data, byte 0 in bits 7:0 |

## Verification
The transmit side is driven with standard, extended and remote messages of differing lengths. Committing past four messages separates the unsent count from the storage occupancy, because the engine pops every entry before any confirmation arrives. Confirmations arriving with nothing in flight, a clear that lands in the same cycle as a set, and non-key pointer writes test the two ignore rules. On the receive side, a burst longer than the queue separates storing from dropping. A long held arrival stream drives the overrun counter into saturation, and releases on an empty queue show whether the pointers stay intact.

// File: rtl/can_fifo_pkg.sv
`timescale 1ns/1ps
package can_fifo_pkg;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;

    // control region, above the 64 mailbox slots
    localparam logic [ADDR_W-1:0] A_TXCTL = 9'h100;
    localparam logic [ADDR_W-1:0] A_TXPTR = 9'h101;
    localparam logic [ADDR_W-1:0] A_RXCTL = 9'h102;
    localparam logic [ADDR_W-1:0] A_RXPTR = 9'h103;
    localparam logic [ADDR_W-1:0] A_IEN   = 9'h104;
    localparam logic [ADDR_W-1:0] A_ISTAT = 9'h105;
    localparam logic [ADDR_W-1:0] A_OVRN  = 9'h106;

    localparam logic [7:0] PTR_KEY = 8'hFF;

    localparam int IRQ_TX_BIT = 3;
    localparam int IRQ_RX_BIT = 4;
    localparam int RXCTL_EMPTY_BIT = 7;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  dlc;
        logic [63:0] data;
    } can_msg_t;

    localparam int MSG_W = $bits(can_msg_t);

    function automatic logic [ADDR_W-1:0] slot_base(input int slot);
        return ADDR_W'(slot * 4);
    endfunction

endpackage

// File: rtl/can_msg_fifo.sv
`timescale 1ns/1ps
module can_msg_fifo #(
    parameter int WIDTH = 100,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [WIDTH-1:0]               din,
    input  logic                           pop,
    output logic [WIDTH-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> $stable(count));

endmodule

// File: rtl/can_tx_window.sv
`timescale 1ns/1ps
module can_tx_window
    import can_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    output can_msg_t    stage
);
    localparam int NWORDS = 2;

    logic [31:0] id_q;
    logic [3:0]  dlc_q;
    logic [31:0] dword [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= '0;
            dlc_q <= '0;
        end else if (we) begin
            if (sel == 2'd0) id_q  <= wdata;
            if (sel == 2'd1) dlc_q <= wdata[3:0];
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_dword
        always_ff @(posedge clk) begin
            if (rst)                              dword[g] <= '0;
            else if (we && sel == 2'(g + 2))      dword[g] <= wdata;
        end
    end

    assign stage.id   = id_q;
    assign stage.dlc  = dlc_q;
    assign stage.data = {dword[1], dword[0]};

endmodule

// File: rtl/can_tx_track.sv
`timescale 1ns/1ps
module can_tx_track #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_req,
    input  logic             done_req,
    input  logic [CNT_W-1:0] occupancy,
    output logic             commit_ok,
    output logic             done_ok,
    output logic [CNT_W-1:0] unsent
);
    logic [CNT_W-1:0] unsent_q;

    assign commit_ok = commit_req && (unsent_q < CNT_W'(DEPTH));
    // only a message already handed to the engine can be confirmed
    assign done_ok   = done_req && (unsent_q > occupancy);
    assign unsent    = unsent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unsent_q <= '0;
        end else begin
            case ({commit_ok, done_ok})
                2'b10:   unsent_q <= unsent_q + 1'b1;
                2'b01:   unsent_q <= unsent_q - 1'b1;
                default: unsent_q <= unsent_q;
            endcase
        end
    end

    // R4
    unsent_cover_chk: assert property (@(posedge clk) disable iff (rst)
        unsent >= occupancy);

    // R4
    commit_block_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_req && unsent == CNT_W'(DEPTH) && !done_req) |=> $stable(unsent));

endmodule

// File: rtl/can_fifo_irq.sv
`timescale 1ns/1ps
module can_fifo_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ien_we,
    input  logic            isr_we,
    input  logic [NSRC-1:0] wbits,
    input  logic [NSRC-1:0] set,
    output logic [NSRC-1:0] ien,
    output logic [NSRC-1:0] isr,
    output logic            irq
);
    logic ien_q [NSRC];
    logic isr_q [NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                ien_q[i] <= 1'b0;
                isr_q[i] <= 1'b0;
            end else begin
                if (ien_we) ien_q[i] <= wbits[i];
                if (set[i])      isr_q[i] <= 1'b1;
                else if (isr_we) isr_q[i] <= isr_q[i] & wbits[i];
            end
        end
        assign ien[i] = ien_q[i];
        assign isr[i] = isr_q[i];

        // R9
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> isr[i]);

        // R9
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(isr[i]) |-> ($past(isr_we) && !$past(wbits[i])));
    end

    assign irq = |(isr & ien);

endmodule

// File: rtl/can_fifo_window.sv
`timescale 1ns/1ps
module can_fifo_window
    import can_fifo_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int TX_SLOT = 56,
    parameter int RX_SLOT = 60,
    parameter int OVR_W   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [8:0]  cpu_addr,
    input  logic        cpu_we,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        irq,
    output logic        eng_tx_valid,
    input  logic        eng_tx_ready,
    output logic [31:0] eng_tx_id,
    output logic [3:0]  eng_tx_dlc,
    output logic [63:0] eng_tx_data,
    input  logic        eng_tx_done,
    input  logic        eng_rx_valid,
    output logic        eng_rx_ready,
    input  logic [31:0] eng_rx_id,
    input  logic [3:0]  eng_rx_dlc,
    input  logic [63:0] eng_rx_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] TX_BASE = slot_base(TX_SLOT);
    localparam logic [ADDR_W-1:0] RX_BASE = slot_base(RX_SLOT);
    localparam logic [ADDR_W-3:0] TX_SLOT_W = (ADDR_W-2)'(TX_SLOT);

    // ---------------- register strobes ----------------
    logic stage_we, key_low;
    logic commit_req, release_req;
    logic tx_en, rx_en;

    assign key_low     = (cpu_wdata[7:0] == PTR_KEY);
    assign stage_we    = cpu_we && (cpu_addr[ADDR_W-1:2] == TX_SLOT_W);
    assign commit_req  = cpu_we && (cpu_addr == A_TXPTR) && key_low && tx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (cpu_we) begin
            if (cpu_addr == A_TXCTL) tx_en <= cpu_wdata[0];
            if (cpu_addr == A_RXCTL) rx_en <= cpu_wdata[0];
        end
    end

    // ---------------- transmit path ----------------
    can_msg_t         stage, tx_head;
    logic [MSG_W-1:0] tx_dout;
    logic [CNT_W-1:0] tx_count, unsent;
    logic             tx_full, tx_empty, commit_ok, done_ok, tx_pop;

    can_tx_window u_stage (
        .clk   (clk),
        .rst   (rst),
        .we    (stage_we),
        .sel   (cpu_addr[1:0]),
        .wdata (cpu_wdata),
        .stage (stage)
    );

    can_tx_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .commit_req (commit_req),
        .done_req   (eng_tx_done),
        .occupancy  (tx_count),
        .commit_ok  (commit_ok),
        .done_ok    (done_ok),
        .unsent     (unsent)
    );

    can_msg_fifo #(.WIDTH(MSG_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (commit_ok),
        .din   (stage),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign tx_head      = can_msg_t'(tx_dout);
    assign eng_tx_valid = tx_en && !tx_empty;
    assign tx_pop       = eng_tx_valid && eng_tx_ready;
    assign eng_tx_id    = tx_head.id;
    assign eng_tx_dlc   = tx_head.dlc;
    assign eng_tx_data  = tx_head.data;

    // ---------------- receive path ----------------
    can_msg_t         rx_in, rx_head;
    logic [MSG_W-1:0] rx_dout;
    logic [CNT_W-1:0] rx_count;
    logic             rx_full, rx_empty, rx_push, rx_store, rx_drop;
    logic [OVR_W-1:0] ovr_q;

    assign rx_in        = '{id: eng_rx_id, dlc: eng_rx_dlc, data: eng_rx_data};
    assign eng_rx_ready = rx_en;
    assign rx_push      = eng_rx_valid && rx_en;
    assign rx_store     = rx_push && !rx_full;
    assign rx_drop      = rx_push && rx_full;
    assign release_req  = cpu_we && (cpu_addr == A_RXPTR) && key_low;

    can_msg_fifo #(.WIDTH(MSG_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (rx_in),
        .pop   (release_req),
        .dout  (rx_dout),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign rx_head = rx_empty ? '0 : can_msg_t'(rx_dout);

    always_ff @(posedge clk) begin
        if (rst)                                 ovr_q <= '0;
        else if (rx_drop && ovr_q != '1)         ovr_q <= ovr_q + 1'b1;
    end

    // ---------------- interrupts ----------------
    logic [1:0] ien, isr;

    can_fifo_irq #(.NSRC(2)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .ien_we (cpu_we && cpu_addr == A_IEN),
        .isr_we (cpu_we && cpu_addr == A_ISTAT),
        .wbits  ({cpu_wdata[IRQ_RX_BIT], cpu_wdata[IRQ_TX_BIT]}),
        .set    ({rx_store, done_ok}),
        .ien    (ien),
        .isr    (isr),
        .irq    (irq)
    );

    // ---------------- read mux ----------------
    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            TX_BASE:        cpu_rdata = stage.id;
            TX_BASE + 9'd1: cpu_rdata = {28'd0, stage.dlc};
            TX_BASE + 9'd2: cpu_rdata = stage.data[31:0];
            TX_BASE + 9'd3: cpu_rdata = stage.data[63:32];
            RX_BASE:        cpu_rdata = rx_head.id;
            RX_BASE + 9'd1: cpu_rdata = {28'd0, rx_head.dlc};
            RX_BASE + 9'd2: cpu_rdata = rx_head.data[31:0];
            RX_BASE + 9'd3: cpu_rdata = rx_head.data[63:32];
            A_TXCTL:        cpu_rdata = DATA_W'({unsent, tx_en});
            A_RXCTL:        cpu_rdata = DATA_W'({rx_empty, 6'd0, rx_en});
            A_IEN:          cpu_rdata = DATA_W'({ien, 3'd0});
            A_ISTAT:        cpu_rdata = DATA_W'({isr, 3'd0});
            A_OVRN:         cpu_rdata = DATA_W'(ovr_q);
            default:        cpu_rdata = '0;
        endcase
    end

    // R8
    ovr_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ovr_q) |-> (ovr_q == OVR_W'($past(ovr_q) + 1'b1)));

    // R8
    rx_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_drop && !release_req) |=> $stable(rx_count));

    // R4
    tx_full_chk: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> (unsent == CNT_W'(DEPTH)));

endmodule

// File: tb/can_fifo_window_test.sv
`timescale 1ns/1ps
module can_fifo_window_test;

    localparam logic [8:0] A_TXW   = 9'd224;
    localparam logic [8:0] A_RXW   = 9'd240;
    localparam logic [8:0] A_TXCTL = 9'h100;
    localparam logic [8:0] A_TXPTR = 9'h101;
    localparam logic [8:0] A_RXCTL = 9'h102;
    localparam logic [8:0] A_RXPTR = 9'h103;
    localparam logic [8:0] A_IEN   = 9'h104;
    localparam logic [8:0] A_ISR   = 9'h105;
    localparam logic [8:0] A_OVR   = 9'h106;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  dlc;
        logic [63:0] d;
    } frm_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  cpu_addr = A_TXCTL;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        irq;
    logic        tx_valid, tx_ready = 1'b0, tx_done = 1'b0;
    logic [31:0] tx_id;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [31:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;

    always #10 clk = ~clk;

    can_fifo_window uut (
        .clk          (clk),
        .rst          (rst),
        .cpu_addr     (cpu_addr),
        .cpu_we       (cpu_we),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .irq          (irq),
        .eng_tx_valid (tx_valid),
        .eng_tx_ready (tx_ready),
        .eng_tx_id    (tx_id),
        .eng_tx_dlc   (tx_dlc),
        .eng_tx_data  (tx_data),
        .eng_tx_done  (tx_done),
        .eng_rx_valid (rx_valid),
        .eng_rx_ready (rx_ready),
        .eng_rx_id    (rx_id),
        .eng_rx_dlc   (rx_dlc),
        .eng_rx_data  (rx_data)
    );

    // ---------------- reference model state ----------------
    frm_t        st;
    frm_t        txq[$];
    frm_t        rxq[$];
    int          unsent, ovr;
    bit          tx_en, rx_en, ien_tx, ien_rx, f_tx, f_rx;
    int          checks = 0, errors = 0;
    bit          finished = 0;

    task automatic model_reset();
        st = '0; txq.delete(); rxq.delete();
        unsent = 0; ovr = 0;
        tx_en = 0; rx_en = 0; ien_tx = 0; ien_rx = 0; f_tx = 0; f_rx = 0;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [8:0] a);
        frm_t h;
        h = (rxq.size() > 0) ? rxq[0] : '0;
        case (a)
            A_TXW:        return st.id;
            A_TXW + 9'd1: return {28'd0, st.dlc};
            A_TXW + 9'd2: return st.d[31:0];
            A_TXW + 9'd3: return st.d[63:32];
            A_RXW:        return h.id;
            A_RXW + 9'd1: return {28'd0, h.dlc};
            A_RXW + 9'd2: return h.d[31:0];
            A_RXW + 9'd3: return h.d[63:32];
            A_TXCTL:      return 32'(unsent * 2 + int'(tx_en));
            A_RXCTL:      return 32'((rxq.size() == 0 ? 128 : 0) + int'(rx_en));
            A_IEN:        return 32'(int'(ien_rx) * 16 + int'(ien_tx) * 8);
            A_ISR:        return 32'(int'(f_rx) * 16 + int'(f_tx) * 8);
            A_OVR:        return 32'(ovr);
            default:      return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [8:0] a);
        if (a >= A_TXW && a < A_TXW + 9'd4) return "R2";
        if (a >= A_RXW && a < A_RXW + 9'd4) return "R6";
        case (a)
            A_TXCTL: return "R4";
            A_RXCTL: return "R6";
            A_IEN, A_ISR: return "R9";
            A_OVR:   return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic compare();
        chk("R6", "eng_rx_ready", rx_ready, rx_en);
        chk("R5", "eng_tx_valid", tx_valid, tx_en && txq.size() > 0);
        if (tx_en && txq.size() > 0)
            chk("R2", "tx message", {tx_id, tx_dlc, tx_data}, txq[0]);
        chk("R9", "irq", irq, (f_rx & ien_rx) | (f_tx & ien_tx));
        chk(tag_of(cpu_addr), "cpu_rdata", cpu_rdata, model_rd(cpu_addr));
    endtask

    task automatic model_update();
        bit commit, rel, pop, done, arrive, store;
        frm_t inf;
        commit = cpu_we && cpu_addr == A_TXPTR && cpu_wdata[7:0] == 8'hFF && tx_en && unsent < 4;
        rel    = cpu_we && cpu_addr == A_RXPTR && cpu_wdata[7:0] == 8'hFF && rxq.size() > 0;
        pop    = tx_en && txq.size() > 0 && tx_ready;
        done   = tx_done && unsent > txq.size();
        arrive = rx_en && rx_valid;
        store  = arrive && rxq.size() < 4;
        inf    = '{id: rx_id, dlc: rx_dlc, d: rx_data};
        if (pop) void'(txq.pop_front());
        if (commit) txq.push_back(st);
        unsent = unsent + int'(commit) - int'(done);
        if (rel) void'(rxq.pop_front());
        if (store) rxq.push_back(inf);
        if (arrive && !store && ovr < 255) ovr++;
        if (cpu_we && cpu_addr == A_ISR) begin
            f_tx = f_tx & cpu_wdata[3];
            f_rx = f_rx & cpu_wdata[4];
        end
        if (done)  f_tx = 1;
        if (store) f_rx = 1;
        if (cpu_we) begin
            case (cpu_addr)
                A_TXW:        st.id  = cpu_wdata;
                A_TXW + 9'd1: st.dlc = cpu_wdata[3:0];
                A_TXW + 9'd2: st.d[31:0]  = cpu_wdata;
                A_TXW + 9'd3: st.d[63:32] = cpu_wdata;
                A_TXCTL:      tx_en = cpu_wdata[0];
                A_RXCTL:      rx_en = cpu_wdata[0];
                A_IEN: begin ien_tx = cpu_wdata[3]; ien_rx = cpu_wdata[4]; end
                default: ;
            endcase
        end
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d;
        step();
        cpu_we = 1'b0; cpu_wdata = '0;
    endtask

    task automatic expect_reg(input logic [8:0] a, input logic [31:0] e, input string req);
        cpu_addr = a; cpu_we = 1'b0;
        #1 chk(req, $sformatf("reg %h", a), cpu_rdata, e);
    endtask

    task automatic stage_msg(input frm_t f);
        wr(A_TXW, f.id);
        wr(A_TXW + 9'd1, {28'd0, f.dlc});
        wr(A_TXW + 9'd2, f.d[31:0]);
        wr(A_TXW + 9'd3, f.d[63:32]);
    endtask

    task automatic push_rx(input frm_t f);
        rx_valid = 1'b1; rx_id = f.id; rx_dlc = f.dlc; rx_data = f.d;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic pulse_done();
        tx_done = 1'b1; step(); tx_done = 1'b0;
    endtask

    function automatic frm_t mk(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] d);
        return '{id: id, dlc: dlc, d: d};
    endfunction

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        frm_t f0, f1, f2, f3, f4, r0, r1, r2, r3, r4, r5;
        f0 = mk(32'h123 << 18, 4'd8, 64'h8877_6655_4433_2211);
        f1 = mk(32'h8000_0000 | 32'h1ABC_DEF0, 4'd3, 64'h0000_0000_00CC_BBAA);
        f2 = mk(32'h4000_0000 | (32'h7FF << 18), 4'd0, 64'h0);
        f3 = mk(32'hC000_0000 | 32'h0000_0001, 4'd15, 64'hFFEE_DDCC_BBAA_9988);
        f4 = mk(32'h055 << 18, 4'd1, 64'h42);
        r0 = mk(32'h301 << 18, 4'd2, 64'hBEEF);
        r1 = mk(32'h9000_0005, 4'd8, 64'h0102_0304_0506_0708);
        r2 = mk(32'h4000_0000 | (32'h011 << 18), 4'd4, 64'h0);
        r3 = mk(32'h7FF << 18, 4'd5, 64'h11_2233_4455);
        r4 = mk(32'h0AA << 18, 4'd1, 64'h99);
        r5 = mk(32'h8FFF_FFFF, 4'd6, 64'hABCD_EF01_2345);

        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg(A_RXCTL, 32'h80, "R1");
        expect_reg(A_TXCTL, 32'h0, "R1");
        expect_reg(A_ISR, 32'h0, "R1");
        expect_reg(A_OVR, 32'h0, "R1");
        chk("R1", "irq", irq, 1'b0);
        chk("R1", "eng_tx_valid", tx_valid, 1'b0);
        chk("R1", "eng_rx_ready", rx_ready, 1'b0);

        // R3 commit while disabled is ignored
        stage_msg(f0);
        wr(A_TXPTR, 32'hFF);
        expect_reg(A_TXCTL, 32'h0, "R3");
        chk("R5", "tx_valid while disabled", tx_valid, 1'b0);

        wr(A_TXCTL, 32'h1);
        wr(A_RXCTL, 32'h1);
        wr(A_IEN, 32'h18);

        wr(A_TXPTR, 32'hFF);
        expect_reg(A_TXCTL, 32'h3, "R4");
        chk("R2", "first message", {tx_id, tx_dlc, tx_data}, f0);
        wr(A_TXPTR, 32'h7F);
        expect_reg(A_TXCTL, 32'h3, "R3");

        stage_msg(f1); wr(A_TXPTR, 32'hFF);
        stage_msg(f2); wr(A_TXPTR, 32'hFF);
        stage_msg(f3); wr(A_TXPTR, 32'hFF);
        expect_reg(A_TXCTL, 32'h9, "R4");
        stage_msg(f4); wr(A_TXPTR, 32'hFF);
        expect_reg(A_TXCTL, 32'h9, "R4");
        expect_reg(A_TXW, f4.id, "R2");

        // R5 ordering while engine drains
        tx_ready = 1'b1;
        step();
        chk("R5", "second in order", {tx_id, tx_dlc, tx_data}, f1);
        idle(4);
        tx_ready = 1'b0;
        chk("R5", "drained", tx_valid, 1'b0);
        expect_reg(A_TXCTL, 32'h9, "R4");

        pulse_done();
        expect_reg(A_TXCTL, 32'h7, "R4");
        expect_reg(A_ISR, 32'h08, "R9");
        chk("R9", "irq tx", irq, 1'b1);
        wr(A_ISR, 32'hF7);
        expect_reg(A_ISR, 32'h0, "R9");

        // R9 set wins over clear in the same cycle
        cpu_addr = A_ISR; cpu_we = 1'b1; cpu_wdata = 32'hF7; tx_done = 1'b1;
        step();
        cpu_we = 1'b0; tx_done = 1'b0;
        expect_reg(A_ISR, 32'h08, "R9");
        wr(A_IEN, 32'h10);
        chk("R9", "irq masked", irq, 1'b0);
        wr(A_IEN, 32'h18);
        chk("R9", "irq unmasked", irq, 1'b1);

        pulse_done(); pulse_done();
        expect_reg(A_TXCTL, 32'h1, "R4");
        pulse_done();
        expect_reg(A_TXCTL, 32'h1, "R4");
        wr(A_ISR, 32'hF7);

        // receive side
        push_rx(r0);
        expect_reg(A_RXCTL, 32'h01, "R6");
        expect_reg(A_RXW, r0.id, "R6");
        expect_reg(A_ISR, 32'h10, "R9");
        push_rx(r1); push_rx(r2); push_rx(r3);
        push_rx(r4);
        expect_reg(A_OVR, 32'd1, "R8");
        expect_reg(A_RXW, r0.id, "R8");
        wr(A_RXPTR, 32'hFF);
        expect_reg(A_RXW, r1.id, "R7");
        expect_reg(A_RXW + 9'd3, r1.d[63:32], "R6");
        wr(A_RXPTR, 32'h00);
        expect_reg(A_RXW, r1.id, "R7");
        wr(A_RXPTR, 32'hFF); wr(A_RXPTR, 32'hFF); wr(A_RXPTR, 32'hFF);
        expect_reg(A_RXCTL, 32'h81, "R6");
        expect_reg(A_RXW, 32'h0, "R6");
        wr(A_RXPTR, 32'hFF);
        push_rx(r5);
        expect_reg(A_RXW, r5.id, "R7");
        expect_reg(A_RXW + 9'd1, 32'd6, "R7");

        // R8 saturation under a held arrival stream
        rx_valid = 1'b1; rx_id = r4.id; rx_dlc = r4.dlc; rx_data = r4.d;
        idle(300);
        rx_valid = 1'b0;
        expect_reg(A_OVR, 32'd255, "R8");
        expect_reg(A_RXW, r5.id, "R8");

        // R6 receive disabled
        wr(A_RXCTL, 32'h0);
        chk("R6", "rx_ready off", rx_ready, 1'b0);
        push_rx(r0);
        expect_reg(A_RXCTL, 32'h00, "R6");
        for (int k = 0; k < 4; k++) wr(A_RXPTR, 32'hFF);
        expect_reg(A_RXCTL, 32'h80, "R6");
        idle(3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule